// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a 256-row dynamic memory alive. Out of reset it waits a programmable settling time. It then runs a fixed burst of dummy refresh cycles. Once that burst is done it raises a ready flag, and the access controller may start normal traffic from that point on.

After that, a free-running interval timer produces one refresh request per interval, so every row is visited well inside the retention window. The block never takes the memory strobes by itself. It raises a request, waits for the access controller to grant the bus, and only then drives the row strobe, both column strobes and the write enable.

The default cycle is the counter-based kind: the column strobes fall first and the memory supplies the row internally. A parameter selects a row-address variant instead. In that variant the column strobes stay idle and an internal 8-bit row counter is driven onto the address pins. Refresh ticks that arrive while the grant is withheld are stored, up to a bound, and run back to back once the grant comes.

Top module: `refseq_top`

## Requirements
- R1: While reset is held and right after it, the row strobe, both column strobes and the write enable are high (inactive), and the request, ready flag and address enable are low.
- R2: The request first rises exactly INIT_WAIT clock edges after reset is released. Exactly INIT_CYCLES refresh cycles (8 by default) run before the ready flag rises. The ready flag then stays high until the next reset.
- R3: A refresh cycle starts only when the grant is seen high. The request stays high while any refresh is owed or a cycle is in progress, and it drops once none is owed. A cycle that has started runs to completion even if the grant is removed.
- R4: In counter-based mode, both column strobes go low exactly T_CSR cycles before the row strobe falls. They stay low for exactly T_CHR cycles after it falls. The write enable stays high, and the address enable stays low at all times.
- R5: The row strobe stays low for exactly T_RAS cycles per refresh and high for at least T_RP cycles between refreshes. A column strobe never falls sooner than T_RPC cycles after the row strobe rises.
- R6: After initialization, with the grant held high, successive row-strobe falls are exactly INTERVAL cycles apart. The timer restarts whenever a refresh is issued, and the issue cycle counts as the first cycle of the new interval.
- R7: Ticks that arrive while the grant is withheld are counted, and the count saturates at MAX_PEND. When the grant returns, the owed cycles run back to back. In counter-based mode, consecutive row-strobe falls are then T_CSR+T_RAS+T_RP cycles apart.
- R8: In row-address mode (RAS_ONLY=1), both column strobes stay high and the address enable is high during each refresh cycle. The driven row starts at 0 after reset, advances by one after every cycle, and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_req | output | 1 | Request for the memory bus |
| ref_gnt | input | 1 | Bus grant from the access controller |
| init_done | output | 1 | Power-up sequence finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Row counter value for row-address mode |
| row_addr_oe | output | 1 | Address pins driven by this block |

## Verification
The scheduler is exercised in four grant patterns:
- The grant is withheld during power-up. This separates "waits for grant" from "starts on its own".
- The grant is held high continuously. This exposes the exact interval spacing and the timer restart.
- The grant is removed for slightly under three intervals. This checks that exactly the ticks that occurred are stored.
- The grant is removed for many intervals. This shows saturation at the pending limit and the back-to-back replay spacing.

A second instance in row-address mode runs until its row counter wraps. That run checks that the column strobes stay idle and that the driven rows step by one.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
   typedef enum logic [1:0] {CY_IDLE, CY_CSR, CY_RAS, CY_RP} cyc_state_t;
   typedef enum logic [1:0] {PH_WAIT, PH_INIT, PH_RUN} phase_t;
endpackage

// File: rtl/refseq_sched.sv
module refseq_sched
   import refseq_pkg::*;
#(
   parameter int INIT_WAIT   = 20000,
   parameter int INTERVAL    = 3120,
   parameter int INIT_CYCLES = 8,
   parameter int MAX_PEND    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   output logic pend_nz,
   output logic init_done
);
   localparam int TMAX = (INIT_WAIT > INTERVAL) ? INIT_WAIT : INTERVAL;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int PW   = $clog2(MAX_PEND + 1);

   if (INIT_CYCLES > MAX_PEND) begin : g_bad_init
      $error("INIT_CYCLES must not exceed MAX_PEND");
   end
   if (INTERVAL < 2 || INIT_WAIT < 1) begin : g_bad_time
      $error("INTERVAL must be >= 2 and INIT_WAIT >= 1");
   end

   phase_t          phase;
   logic [TW-1:0]   tmr;
   logic [PW-1:0]   pend;
   logic            tick;
   logic            inc;

   assign tick = (phase == PH_RUN) && (tmr == TW'(INTERVAL - 1));
   assign inc  = tick && (pend != PW'(MAX_PEND));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_WAIT;
         tmr   <= '0;
         pend  <= '0;
      end else begin
         case (phase)
            PH_WAIT: begin
               if (tmr == TW'(INIT_WAIT - 1)) begin
                  phase <= PH_INIT;
                  pend  <= PW'(INIT_CYCLES);
                  tmr   <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            PH_INIT: begin
               if (start) pend <= pend - 1'b1;
               else if (pend == '0 && !busy) begin
                  phase <= PH_RUN;
                  tmr   <= '0;
               end
            end
            default: begin
               if (start)     tmr <= TW'(1);
               else if (tick) tmr <= '0;
               else           tmr <= tmr + 1'b1;
               pend <= pend + PW'(inc) - PW'(start);
            end
         endcase
      end
   end

   assign pend_nz   = (pend != '0);
   assign init_done = (phase == PH_RUN);

   p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PW'(MAX_PEND))
      else $error("pending count above limit");
   p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done)
      else $error("ready flag dropped");
   p_start_owed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> pend != '0)
      else $error("cycle started with nothing owed");
endmodule

// File: rtl/refseq_cycle.sv
module refseq_cycle
   import refseq_pkg::*;
#(
   parameter bit RAS_ONLY = 1'b0,
   parameter int T_CSR    = 1,
   parameter int T_CHR    = 2,
   parameter int T_RAS    = 8,
   parameter int T_RP     = 5,
   parameter int T_RPC    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_nz,
   input  logic gnt,
   output logic start,
   output logic busy,
   output logic row_step,
   output logic ras_n,
   output logic cas_n
);
   localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
   localparam int CMAX = (M1 > T_RP) ? M1 : T_RP;
   localparam int CW   = $clog2(CMAX + 1);
   localparam cyc_state_t FIRST = RAS_ONLY ? CY_RAS : CY_CSR;

   if (T_CSR < 1 || T_RAS < 2 || T_RP < 1 || T_CHR < 1 || T_CHR >= T_RAS) begin : g_bad_len
      $error("strobe timing parameters out of range");
   end
   if (T_RP < T_RPC) begin : g_bad_rpc
      $error("T_RP must cover T_RPC");
   end

   cyc_state_t      st;
   logic [CW-1:0]   cnt;
   logic            can_go;
   logic            rp_end;

   assign can_go = pend_nz && gnt;
   assign rp_end = (st == CY_RP) && (cnt == CW'(T_RP - 1));
   assign start  = can_go && ((st == CY_IDLE) || rp_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CY_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            CY_IDLE: if (can_go) begin st <= FIRST; cnt <= '0; end
            CY_CSR:
               if (cnt == CW'(T_CSR - 1)) begin st <= CY_RAS; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            CY_RAS:
               if (cnt == CW'(T_RAS - 1)) begin st <= CY_RP; cnt <= '0; end
               else cnt <= cnt + 1'b1;
            default:
               if (rp_end) begin
                  st  <= can_go ? FIRST : CY_IDLE;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
         endcase
      end
   end

   assign busy     = (st != CY_IDLE);
   assign ras_n    = (st != CY_RAS);
   assign row_step = (st == CY_RAS) && (cnt == CW'(T_RAS - 1));

   if (RAS_ONLY) begin : g_row_mode
      assign cas_n = 1'b1;
   end else begin : g_cbr_mode
      assign cas_n = !((st == CY_CSR) || ((st == CY_RAS) && (cnt < CW'(T_CHR))));
      p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ras_n) |-> !cas_n && $past(!cas_n))
         else $error("row strobe fell without column strobe low");
   end

   p_grant_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(gnt))
      else $error("cycle began without grant");
endmodule

// File: rtl/refseq_rowctr.sv
module refseq_rowctr #(
   parameter bit RAS_ONLY = 1'b0,
   parameter int ROW_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic                busy,
   output logic [ROW_BITS-1:0] addr,
   output logic                addr_oe
);
   if (ROW_BITS < 1) begin : g_bad_rows
      $error("ROW_BITS must be positive");
   end

   logic [ROW_BITS-1:0] row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    row <= '0;
      else if (step) row <= row + 1'b1;
   end

   if (RAS_ONLY) begin : g_drive
      assign addr    = row;
      assign addr_oe = busy;
      p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(addr_oe) |-> addr == $past(addr))
         else $error("row changed while cycle closing");
   end else begin : g_quiet
      assign addr    = '0;
      assign addr_oe = 1'b0;
   end
endmodule

// File: rtl/refseq_top.sv
module refseq_top #(
   parameter int INIT_WAIT   = 20000,
   parameter int INTERVAL    = 3120,
   parameter int INIT_CYCLES = 8,
   parameter int MAX_PEND    = 8,
   parameter int T_CSR       = 1,
   parameter int T_CHR       = 2,
   parameter int T_RAS       = 8,
   parameter int T_RP        = 5,
   parameter int T_RPC       = 1,
   parameter bit RAS_ONLY    = 1'b0,
   parameter int ROW_BITS    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                ref_req,
   input  logic                ref_gnt,
   output logic                init_done,
   output logic                ras_n,
   output logic                cas_lo_n,
   output logic                cas_hi_n,
   output logic                we_n,
   output logic [ROW_BITS-1:0] row_addr,
   output logic                row_addr_oe
);
   localparam int LW = $clog2(T_RAS + 1);
   localparam int GW = $clog2(T_RPC + 1);

   logic start, busy, pend_nz, row_step, cas_n;

   refseq_sched #(.INIT_WAIT(INIT_WAIT), .INTERVAL(INTERVAL),
                  .INIT_CYCLES(INIT_CYCLES), .MAX_PEND(MAX_PEND)) u_sched (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .pend_nz(pend_nz), .init_done(init_done));

   refseq_cycle #(.RAS_ONLY(RAS_ONLY), .T_CSR(T_CSR), .T_CHR(T_CHR),
                  .T_RAS(T_RAS), .T_RP(T_RP), .T_RPC(T_RPC)) u_cycle (
      .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .gnt(ref_gnt),
      .start(start), .busy(busy), .row_step(row_step),
      .ras_n(ras_n), .cas_n(cas_n));

   refseq_rowctr #(.RAS_ONLY(RAS_ONLY), .ROW_BITS(ROW_BITS)) u_row (
      .clk(clk), .rst_n(rst_n), .step(row_step), .busy(busy),
      .addr(row_addr), .addr_oe(row_addr_oe));

   assign ref_req  = pend_nz || busy;
   assign cas_lo_n = cas_n;
   assign cas_hi_n = cas_n;
   assign we_n     = 1'b1;

   // Observation counters for the strobe-width properties.
   logic [LW-1:0] low_run;
   logic [GW-1:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= GW'(T_RPC);
      end else begin
         if (!ras_n) low_run <= (low_run == LW'(T_RAS)) ? low_run : low_run + 1'b1;
         else        low_run <= '0;
         if (ras_n)  high_run <= (high_run == GW'(T_RPC)) ? high_run : high_run + 1'b1;
         else        high_run <= '0;
      end
   end

   p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> low_run == LW'(T_RAS))
      else $error("row strobe width wrong");
   p_rpc_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_lo_n) |-> high_run >= GW'(T_RPC))
      else $error("column strobe fell too soon after row strobe rose");

   if (!RAS_ONLY) begin : g_chr_chk
      p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(cas_lo_n) && !ras_n) |-> low_run == LW'(T_CHR))
         else $error("column hold after row strobe wrong");
   end
endmodule

// File: tb/refseq_top_bench.sv
`timescale 1ns/1ps
module refseq_top_bench;
   localparam int IW = 40, IV = 60, NI = 8, MP = 8;
   localparam int CSR = 2, CHR = 3, RAS = 5, RP = 4, RPC = 2;
   localparam int CYC = CSR + RAS + RP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b0;
   logic gnt_ro = 1'b1;
   always #2.5 clk = ~clk;

   logic req, rdy, ras_n, casl, cash, we_n, oe;
   logic [7:0] addr;
   logic req_ro, rdy_ro, ras_ro, casl_ro, cash_ro, we_ro, oe_ro;
   logic [7:0] addr_ro;

   refseq_top #(.INIT_WAIT(IW), .INTERVAL(IV), .INIT_CYCLES(NI), .MAX_PEND(MP),
      .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP), .T_RPC(RPC),
      .RAS_ONLY(1'b0), .ROW_BITS(8)) u_refseq_top (
      .clk(clk), .rst_n(rst_n), .ref_req(req), .ref_gnt(gnt), .init_done(rdy),
      .ras_n(ras_n), .cas_lo_n(casl), .cas_hi_n(cash), .we_n(we_n),
      .row_addr(addr), .row_addr_oe(oe));

   refseq_top #(.INIT_WAIT(IW), .INTERVAL(IV), .INIT_CYCLES(NI), .MAX_PEND(MP),
      .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP), .T_RPC(RPC),
      .RAS_ONLY(1'b1), .ROW_BITS(8)) u_refseq_top_ro (
      .clk(clk), .rst_n(rst_n), .ref_req(req_ro), .ref_gnt(gnt_ro), .init_done(rdy_ro),
      .ras_n(ras_ro), .cas_lo_n(casl_ro), .cas_hi_n(cash_ro), .we_n(we_ro),
      .row_addr(addr_ro), .row_addr_oe(oe_ro));

   int checks = 0, fails = 0;
   int edges = 0, ncyc = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   always @(posedge clk) if (rst_n) edges++;

   // Strobe monitor for the counter-based instance, sampled at negedge.
   int falls = 0, last_fall = 0, prev_fall = 0;
   int lo_run = 0, hi_run = 100, cas_run = 0, both_run = 0;
   int v_csr = 0, v_chr = 0, v_ras = 0, v_rp = 0, v_rpc = 0, v_we = 0, v_oe = 0;
   logic p_ras = 1'b1, p_cas = 1'b1;
   // Monitor for the row-address instance.
   int ro_falls = 0, v_ro_addr = 0, v_ro_cas = 0, v_ro_oe = 0;
   logic [7:0] ro_exp = 8'd0;
   bit wrapped = 1'b0;
   logic p_ras_ro = 1'b1;

   always @(negedge clk) begin
      ncyc++;
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            prev_fall = last_fall; last_fall = ncyc; falls++;
            if (cas_run != CSR) v_csr++;
            if (hi_run < RP) v_rp++;
         end
         if (!p_ras && ras_n && lo_run != RAS) v_ras++;
         if (!p_cas && casl && !ras_n && both_run != CHR) v_chr++;
         if (p_cas && !casl && hi_run < RPC) v_rpc++;
         if (!we_n || casl != cash) v_we++;
         if (oe) v_oe++;
         lo_run   = ras_n ? 0 : lo_run + 1;
         hi_run   = ras_n ? hi_run + 1 : 0;
         cas_run  = (casl == 1'b0 && ras_n) ? cas_run + 1 : (casl ? 0 : cas_run);
         both_run = (!casl && !ras_n) ? both_run + 1 : 0;
         p_ras = ras_n; p_cas = casl;

         if (!casl_ro || !cash_ro || !we_ro) v_ro_cas++;
         if (p_ras_ro && !ras_ro) begin
            ro_falls++;
            if (!oe_ro) v_ro_oe++;
            if (addr_ro != ro_exp) v_ro_addr++;
            if (ro_exp == 8'd0 && ro_falls > 1) wrapped = 1'b1;
            ro_exp = ro_exp + 8'd1;
         end
         p_ras_ro = ras_ro;
      end
   end

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(ras_n && casl && cash && we_n, "R1 strobes idle in reset", {ras_n, casl, cash, we_n}, 15);
      chk(!req && !rdy && !oe && !oe_ro, "R1 req/ready/oe low in reset", {req, rdy, oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && casl && !req, "R1 idle after release", {ras_n, casl, req}, 6);
   endtask

   task automatic t_init_wait;
      for (int i = 0; i < 500 && !req; i++) @(negedge clk);
      chk(edges == IW, "R2 first request edge", edges, IW);
   endtask

   task automatic t_grant_gate;
      repeat (30) @(negedge clk);
      chk(falls == 0 && ras_n && casl, "R3 no cycle before grant", falls, 0);
      chk(req == 1'b1, "R3 request held while owed", req, 1);
   endtask

   task automatic t_init_run;
      gnt = 1'b1;
      for (int i = 0; i < 1000 && !rdy; i++) @(negedge clk);
      chk(falls == NI, "R2 dummy cycles before ready", falls, NI);
      chk(rdy == 1'b1, "R2 ready raised", rdy, 1);
      chk(req == 1'b0, "R3 request drops when nothing owed", req, 0);
   endtask

   task automatic t_interval;
      int f0;
      f0 = falls;
      for (int i = 0; i < 1000 && falls < f0 + 3; i++) @(negedge clk);
      chk(last_fall - prev_fall == IV, "R6 refresh spacing", last_fall - prev_fall, IV);
      chk(rdy == 1'b1, "R2 ready stays high", rdy, 1);
   endtask

   task automatic t_backlog_partial;
      int f0;
      f0 = falls;
      for (int i = 0; i < 1000 && falls == f0; i++) @(negedge clk);
      gnt = 1'b0;
      f0 = falls;
      repeat (150) @(negedge clk);
      chk(falls == f0, "R3 no new cycle while grant withheld", falls - f0, 0);
      chk(lo_run == 0 && ras_n, "R3 started cycle completed without grant", lo_run, 0);
      chk(req == 1'b1, "R3 request held during hold-off", req, 1);
      gnt = 1'b1;
      repeat (30) @(negedge clk);
      chk(falls - f0 == 2, "R7 stored ticks replayed", falls - f0, 2);
      chk(last_fall - prev_fall == CYC, "R7 back-to-back spacing", last_fall - prev_fall, CYC);
   endtask

   task automatic t_backlog_sat;
      int f0;
      gnt = 1'b0;
      repeat (12 * IV) @(negedge clk);
      f0 = falls;
      gnt = 1'b1;
      repeat (MP * CYC + 6) @(negedge clk);
      chk(falls - f0 == MP, "R7 pending saturates at limit", falls - f0, MP);
      chk(last_fall - prev_fall == CYC, "R7 saturated replay spacing", last_fall - prev_fall, CYC);
   endtask

   task automatic t_row_mode;
      for (int i = 0; i < 30000 && ro_falls < 260; i++) @(negedge clk);
      chk(ro_falls >= 260, "R8 row-address cycles ran", ro_falls, 260);
      chk(v_ro_addr == 0, "R8 row sequence 0,1,2..", v_ro_addr, 0);
      chk(wrapped, "R8 row wraps 255 to 0", wrapped, 1);
      chk(v_ro_cas == 0, "R8 column strobes idle", v_ro_cas, 0);
      chk(v_ro_oe == 0, "R8 address enable during cycle", v_ro_oe, 0);
   endtask

   task automatic t_strobe_rules;
      chk(falls > 20, "R4 enough cycles observed", falls, 21);
      chk(v_csr == 0, "R4 column before row lead", v_csr, 0);
      chk(v_chr == 0, "R4 column hold after row fall", v_chr, 0);
      chk(v_we == 0, "R4 write enable high, strobes paired", v_we, 0);
      chk(v_oe == 0, "R4 address enable low in counter mode", v_oe, 0);
      chk(v_ras == 0, "R5 row strobe low width", v_ras, 0);
      chk(v_rp == 0, "R5 row precharge", v_rp, 0);
      chk(v_rpc == 0, "R5 row-rise to column-fall gap", v_rpc, 0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      t_reset();
      t_init_wait();
      t_grant_gate();
      t_init_run();
      t_interval();
      t_backlog_partial();
      t_backlog_sat();
      t_row_mode();
      t_strobe_rules();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end
endmodule